// File: doc/BRIEF.md
# Hysteresis Threshold Crossing Detector

The block compares a signed sample word, taken on every clock cycle, against a programmable upper and a programmable lower threshold. It keeps a two-level state, above or below. The state moves up only when the sample reaches the upper threshold. It moves down only when the sample reaches the lower threshold. Samples between the two thresholds leave the state as it is.

A change of state is confirmed only after the sample has stayed past the new threshold for a programmable number of consecutive cycles. If the sample returns before that count is reached, the pending change is dropped without any event. This removes short up-down-up and down-up-down excursions.

Three filtered pulses are output: upward, downward, and either one. Two raw pulses are also output for custom checking. They mark the first cycle the sample reaches each threshold, with no filtering. Three saturating counters tally the filtered events for coverage. The thresholds and the suppression count are loaded through a small write port that rejects an inverted threshold pair.

Top module: `hyst_xdet`

## Requirements
- R1: While rst_ni is low and until the first clock edge after its release, all pulse outputs, level_o, cfg_err_o and the three counters are 0. The reset values are: upper threshold 2^(DATA_W-2), lower threshold -2^(DATA_W-2), suppression count 4.
- R2: level_o goes 1 only after samples at or above the upper threshold, and goes 0 only after samples at or below the lower threshold. A sample strictly between the thresholds never changes level_o.
- R3: A transition is confirmed on the N-th consecutive cycle in which the sample stays past the new threshold, where N is the suppression count. In the cycle after that sample, rise_o or fall_o is 1 for exactly one cycle and level_o shows the new level. rise_o and fall_o are never 1 together.
- R4: If the sample returns inside the threshold before N consecutive qualifying cycles, the pending transition is cancelled and no filtered pulse is produced. A later qualifying run starts its count from one.
- R5: any_o is 1 exactly when rise_o or fall_o is 1.
- R6: raw_hi_o is 1 in the cycle after a sample at or above the upper threshold whose preceding sample was below it. raw_lo_o is 1 in the cycle after a sample at or below the lower threshold whose preceding sample was above it. Both are independent of filtering.
- R7: rise_cnt_o, fall_cnt_o and any_cnt_o each increment one cycle after each pulse of rise_o, fall_o and any_o respectively. Each saturates at all ones.
- R8: A write with cfg_we_i=1 uses cfg_sel_i to pick the target: 0 is the upper threshold, 1 is the lower threshold, 2 is the suppression count (taken from the low SUPP_W bits). A threshold write that would leave the lower threshold above the upper one is discarded and sets cfg_err_o. Any accepted write clears cfg_err_o. Select value 3 has no effect.
- R9: A suppression count of 0 behaves as 1, so a single qualifying sample confirms.
- R10: The first sample after reset sets the level without any event: 1 if it is at or above the upper threshold, otherwise 0. No filtered or raw pulse results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | DATA_W | Signed sample, taken every cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target select |
| cfg_wdata_i | input | DATA_W | Write data |
| cfg_err_o | output | 1 | Last threshold write was rejected |
| level_o | output | 1 | Confirmed level (1 above, 0 below) |
| rise_o | output | 1 | Filtered upward crossing pulse |
| fall_o | output | 1 | Filtered downward crossing pulse |
| any_o | output | 1 | Union of rise_o and fall_o |
| raw_hi_o | output | 1 | Unfiltered upper-threshold reach pulse |
| raw_lo_o | output | 1 | Unfiltered lower-threshold reach pulse |
| rise_cnt_o | output | EVT_W | Saturating count of rise_o |
| fall_cnt_o | output | EVT_W | Saturating count of fall_o |
| any_cnt_o | output | EVT_W | Saturating count of any_o |

## Verification
The block is driven through three patterns. Runs past a threshold that end one cycle short of the suppression count show that cancellation is silent while the raw pulses still fire. Runs of exactly the count, including samples equal to each threshold, place the confirmation cycle and show that the comparisons are inclusive. Samples that stay between the thresholds after a level change show that the held level is not disturbed. Rejected threshold writes are detected through the level behaviour that would follow if they had been accepted. A count of zero and long toggle trains cover the immediate confirmation and counter saturation.

// File: rtl/hxd_pkg.sv
package hxd_pkg;
  typedef enum logic [1:0] {
    TRK_INIT = 2'd0,
    TRK_LOW  = 2'd1,
    TRK_HIGH = 2'd2
  } trk_state_e;

  typedef enum logic [1:0] {
    CFG_HI   = 2'd0,
    CFG_LO   = 2'd1,
    CFG_SUPP = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/hxd_cfg.sv
module hxd_cfg
  import hxd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SUPP_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [1:0]               sel_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic signed [DATA_W-1:0] hi_o,
  output logic signed [DATA_W-1:0] lo_o,
  output logic [SUPP_W-1:0]        supp_o,
  output logic                     err_o
);
  localparam logic signed [DATA_W-1:0] HI_RST   = DATA_W'(1) <<< (DATA_W-2);
  localparam logic signed [DATA_W-1:0] LO_RST   = -HI_RST;
  localparam logic [SUPP_W-1:0]        SUPP_RST = SUPP_W'(4);

  logic signed [DATA_W-1:0] wd;
  assign wd = signed'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o   <= HI_RST;
      lo_o   <= LO_RST;
      supp_o <= SUPP_RST;
      err_o  <= 1'b0;
    end else if (we_i) begin
      case (sel_i)
        CFG_HI: begin
          if (wd < lo_o) err_o <= 1'b1;
          else begin
            hi_o  <= wd;
            err_o <= 1'b0;
          end
        end
        CFG_LO: begin
          if (wd > hi_o) err_o <= 1'b1;
          else begin
            lo_o  <= wd;
            err_o <= 1'b0;
          end
        end
        CFG_SUPP: begin
          supp_o <= wdata_i[SUPP_W-1:0];
          err_o  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  p_thr_order_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_o <= hi_o);

  p_reject_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == CFG_LO && wd > hi_o) |=> ($stable(lo_o) && err_o));
endmodule

// File: rtl/hxd_track.sv
module hxd_track
  import hxd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SUPP_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [DATA_W-1:0] hi_i,
  input  logic signed [DATA_W-1:0] lo_i,
  input  logic [SUPP_W-1:0]        supp_i,
  output logic                     level_o,
  output logic                     rise_o,
  output logic                     fall_o,
  output logic                     raw_hi_o,
  output logic                     raw_lo_o
);
  trk_state_e        st_q;
  logic [SUPP_W-1:0] cnt_q;
  logic              prev_hi_q, prev_lo_q;
  logic              ge_hi, le_lo, confirm;
  logic [SUPP_W:0]   cnt_inc, supp_eff;

  assign ge_hi    = sample_i >= hi_i;
  assign le_lo    = sample_i <= lo_i;
  assign supp_eff = (supp_i == '0) ? (SUPP_W+1)'(1) : {1'b0, supp_i};
  assign cnt_inc  = {1'b0, cnt_q} + (SUPP_W+1)'(1);
  assign confirm  = cnt_inc >= supp_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= TRK_INIT;
      cnt_q     <= '0;
      prev_hi_q <= 1'b0;
      prev_lo_q <= 1'b0;
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
      raw_hi_o  <= 1'b0;
      raw_lo_o  <= 1'b0;
    end else begin
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
      prev_hi_q <= ge_hi;
      prev_lo_q <= le_lo;
      raw_hi_o  <= (st_q != TRK_INIT) && ge_hi && !prev_hi_q;
      raw_lo_o  <= (st_q != TRK_INIT) && le_lo && !prev_lo_q;
      case (st_q)
        TRK_INIT: begin
          st_q  <= ge_hi ? TRK_HIGH : TRK_LOW;
          cnt_q <= '0;
        end
        TRK_LOW: begin
          if (!ge_hi) cnt_q <= '0;
          else if (confirm) begin
            st_q   <= TRK_HIGH;
            rise_o <= 1'b1;
            cnt_q  <= '0;
          end else cnt_q <= cnt_inc[SUPP_W-1:0];
        end
        TRK_HIGH: begin
          if (!le_lo) cnt_q <= '0;
          else if (confirm) begin
            st_q   <= TRK_LOW;
            fall_o <= 1'b1;
            cnt_q  <= '0;
          end else cnt_q <= cnt_inc[SUPP_W-1:0];
        end
        default: st_q <= TRK_INIT;
      endcase
    end
  end

  assign level_o = (st_q == TRK_HIGH);

  p_one_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

  p_rise_from_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> ($past(st_q) == TRK_LOW && st_q == TRK_HIGH));

  p_fall_from_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> ($past(st_q) == TRK_HIGH && st_q == TRK_LOW));

  p_init_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == TRK_INIT) |-> !(rise_o || fall_o || raw_hi_o || raw_lo_o));
endmodule

// File: rtl/hxd_sat_cnt.sv
module hxd_sat_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (inc_i && ~&cnt_o)  cnt_o <= cnt_o + W'(1);
  end

  p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_o) |=> (&cnt_o));

  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o >= $past(cnt_o));
endmodule

// File: rtl/hyst_xdet.sv
module hyst_xdet
  import hxd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SUPP_W = 8,
  parameter int EVT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              cfg_err_o,
  output logic              level_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic              any_o,
  output logic              raw_hi_o,
  output logic              raw_lo_o,
  output logic [EVT_W-1:0]  rise_cnt_o,
  output logic [EVT_W-1:0]  fall_cnt_o,
  output logic [EVT_W-1:0]  any_cnt_o
);
  localparam int N_CNT = 3;

  logic signed [DATA_W-1:0] hi_thr, lo_thr;
  logic [SUPP_W-1:0]        supp;
  logic [N_CNT-1:0]         evt;
  logic [EVT_W-1:0]         cnt [N_CNT];

  hxd_cfg #(.DATA_W(DATA_W), .SUPP_W(SUPP_W)) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .hi_o(hi_thr), .lo_o(lo_thr), .supp_o(supp), .err_o(cfg_err_o)
  );

  hxd_track #(.DATA_W(DATA_W), .SUPP_W(SUPP_W)) i_track (
    .clk_i, .rst_ni,
    .sample_i(signed'(sample_i)), .hi_i(hi_thr), .lo_i(lo_thr), .supp_i(supp),
    .level_o, .rise_o, .fall_o, .raw_hi_o, .raw_lo_o
  );

  assign any_o = rise_o | fall_o;
  assign evt   = {any_o, fall_o, rise_o};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    hxd_sat_cnt #(.W(EVT_W)) i_cnt (
      .clk_i, .rst_ni, .inc_i(evt[g]), .cnt_o(cnt[g])
    );
  end

  assign rise_cnt_o = cnt[0];
  assign fall_cnt_o = cnt[1];
  assign any_cnt_o  = cnt[2];

  p_level_needs_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(level_o) != level_o && $past(rst_ni)) |-> (rise_o || fall_o || $past(!rise_o && !fall_o)));
endmodule

// File: tb/test_hyst_xdet.sv
module test_hyst_xdet;
  localparam int DATA_W = 12;
  localparam int SUPP_W = 8;
  localparam int EVT_W  = 4;

  typedef struct packed {
    logic signed [DATA_W-1:0] smp;
    logic rise;
    logic fall;
    logic rhi;
    logic rlo;
    logic lvl;
  } vec_t;

  // hi=100, lo=-100, suppression count 3, level starts low
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{12'sd0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{12'sd150,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{12'sd150,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{12'sd50,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{12'sd150,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{12'sd150,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{12'sd150,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{12'sd150,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{12'sd0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{-12'sd150, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{-12'sd150, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{12'sd0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{-12'sd100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{-12'sd100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{-12'sd100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{12'sd100,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{12'sd100,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{12'sd100,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DATA_W-1:0] sample = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic cfg_err, level, rise, fall, any_evt, raw_hi, raw_lo;
  logic [EVT_W-1:0] rise_cnt, fall_cnt, any_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hyst_xdet #(.DATA_W(DATA_W), .SUPP_W(SUPP_W), .EVT_W(EVT_W)) i_hyst_xdet (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .cfg_err_o(cfg_err), .level_o(level), .rise_o(rise), .fall_o(fall),
    .any_o(any_evt), .raw_hi_o(raw_hi), .raw_lo_o(raw_lo),
    .rise_cnt_o(rise_cnt), .fall_cnt_o(fall_cnt), .any_cnt_o(any_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int val);
    cfg_we    = 1'b1;
    cfg_sel   = sel;
    cfg_wdata = DATA_W'(val);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic step(input int val);
    sample = DATA_W'(val);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 pulses", {rise, fall, any_evt, raw_hi, raw_lo}, 0);
    chk("R1 err", cfg_err, 0);
    chk("R1 counters", {rise_cnt, fall_cnt, any_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 init low", level, 0);

    wr(2'd0, 100);
    wr(2'd1, -100);
    wr(2'd2, 3);
    chk("R8 accepted writes", cfg_err, 0);

    // R2 R3 R4 R5 R6 table walk
    for (int k = 0; k < NV; k++) begin
      step(VECS[k].smp);
      chk($sformatf("R3 rise v%0d", k), rise, VECS[k].rise);
      chk($sformatf("R3 fall v%0d", k), fall, VECS[k].fall);
      chk($sformatf("R5 any v%0d", k), any_evt, VECS[k].rise | VECS[k].fall);
      chk($sformatf("R6 raw_hi v%0d", k), raw_hi, VECS[k].rhi);
      chk($sformatf("R6 raw_lo v%0d", k), raw_lo, VECS[k].rlo);
      chk($sformatf("R2 R4 level v%0d", k), level, VECS[k].lvl);
    end
    @(negedge clk);
    chk("R7 rise count", rise_cnt, 2);
    chk("R7 fall count", fall_cnt, 1);
    chk("R7 any count", any_cnt, 3);

    // R8 lower threshold above upper rejected
    wr(2'd1, 200);
    chk("R8 err on low write", cfg_err, 1);
    for (int k = 0; k < 4; k++) begin
      step(150);
      chk("R8 low unchanged fall", fall, 0);
      chk("R8 low unchanged level", level, 1);
    end
    // R8 upper threshold below lower rejected
    wr(2'd0, -200);
    chk("R8 err on high write", cfg_err, 1);
    for (int k = 0; k < 3; k++) step(-150);
    chk("R8 fall after reject", fall, 1);
    for (int k = 0; k < 4; k++) begin
      step(50);
      chk("R8 high unchanged rise", rise, 0);
      chk("R8 high unchanged level", level, 0);
    end
    wr(2'd3, 0);
    chk("R8 sel 3 keeps err", cfg_err, 1);
    wr(2'd2, 0);
    chk("R8 accepted clears err", cfg_err, 0);

    // R9 zero count confirms at once
    step(150);
    chk("R9 immediate rise", rise, 1);
    chk("R9 level high", level, 1);
    step(-150);
    chk("R9 immediate fall", fall, 1);

    // R7 saturation
    for (int k = 0; k < 20; k++) begin
      step(150);
      step(-150);
    end
    @(negedge clk);
    chk("R7 rise sat", rise_cnt, 15);
    chk("R7 fall sat", fall_cnt, 15);
    chk("R7 any sat", any_cnt, 15);

    // R10 first sample above upper threshold
    rst_n = 1'b0;
    sample = DATA_W'(1500);
    repeat (2) @(negedge clk);
    chk("R1 counters cleared", {rise_cnt, fall_cnt, any_cnt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 init high", level, 1);
    chk("R10 no pulse", {rise, fall, any_evt, raw_hi, raw_lo}, 0);
    @(negedge clk);
    chk("R10 still quiet", {rise, fall, raw_hi, raw_lo}, 0);
    chk("R10 no count", any_cnt, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule